// File: doc/BRIEF.md
# Boot-Block Flash Sector Decoder

This block sits beside the command logic of a 256K x 8 block-erasable flash array. When the controller raises a one-cycle request strobe, the decoder takes the byte address and works out which of five erase blocks it falls in. It returns that block's index, first byte address and length in bytes. It also decides whether a write or erase to that block may go ahead, and if not, why not. All results are registered, so the controller sees stable values one clock after the strobe.

The array is split into a 16 KB boot block, two 8 KB parameter blocks, a 96 KB main block and a 128 KB main block. A strap places the boot block at the top or at the bottom of the address space, and the whole layout mirrors with it.

Every program or erase needs a valid programming supply. The boot block also needs an unlock: the reset pin at super-voltage, or the write-protect pin high. The reset-pin level arrives already digitised, as low, normal high or super-voltage.

Top module: `bootsect_map`

## Requirements
- R1: The boot block is 16 KB and reports index 0. With the strap high (top boot) it covers 0x3C000–0x3FFFF; with the strap low (bottom boot) it covers 0x00000–0x03FFF.
- R2: The two 8 KB parameter blocks report index 1 for the one adjacent to the boot block and index 2 for the next. Top boot: index 1 at 0x3A000, index 2 at 0x38000. Bottom boot: index 1 at 0x04000, index 2 at 0x06000.
- R3: The 96 KB main block reports index 3 and lies next to the parameter blocks: 0x20000–0x37FFF for top boot, 0x08000–0x1FFFF for bottom boot. The 128 KB main block reports index 4 and fills the far end: 0x00000–0x1FFFF for top boot, 0x20000–0x3FFFF for bottom boot.
- R4: The reported base and size are the selected block's first byte address and its length in bytes. The requested address always satisfies base <= address < base + size.
- R5: All outputs load on the clock edge where the request strobe is high. The valid output is high for exactly the following cycle. Without a strobe, every output except valid holds its value.
- R6: With the reset pin at a normal or super level and no valid programming supply, a request is denied with cause 2'b01, whatever block is addressed. This check ranks above the boot lock. Grant and deny are never high together.
- R7: A request to the boot block with a valid supply, the reset pin at normal high and write-protect low is denied with cause 2'b10.
- R8: Write-protect high with a valid supply and a normal-high reset pin grants a request to the boot block.
- R9: A super-voltage reset pin (level code 2'b10) with a valid supply grants a request to any block, with write-protect either high or low.
- R10: Write-protect has no effect on requests to blocks 1 to 4. With a valid supply and the reset pin at normal high, those requests are granted.
- R11: The reset-pin level is coded 2'b00 low, 2'b01 normal high, 2'b10 super-voltage, and 2'b11 is handled as low. With the pin low, a request is denied with cause 2'b11, which ranks above every other cause. A grant carries cause 2'b00.
- R12: While the reset input is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; the inputs below are sampled on this cycle |
| addr_i | input | 18 | Byte address being programmed or erased |
| boot_top_i | input | 1 | Strap: 1 = boot block at top, 0 = at bottom |
| wp_hi_i | input | 1 | Write-protect pin is high |
| rp_lvl_i | input | 2 | Reset-pin level code (see R11) |
| vpp_ok_i | input | 1 | Programming supply valid |
| resp_vld_o | output | 1 | Result valid, one cycle after the strobe |
| blk_idx_o | output | 3 | Block index 0..4 |
| blk_base_o | output | 18 | First byte address of the block |
| blk_size_o | output | 18 | Block length in bytes |
| grant_o | output | 1 | Operation allowed |
| deny_o | output | 1 | Operation refused |
| deny_cause_o | output | 2 | Refusal reason (see R6, R7, R11) |

## Verification
The assertions check the following on every cycle:
- grant and deny are exclusive;
- the requested address lies inside the reported block;
- the response registers hold between strobes;
- the cause ranking for a low reset pin and a missing supply;
- super-voltage always unlocks;
- with write-protect low at normal reset level, only the boot block is refused.

Only the bench's sweeps can show the exact block boundaries, base values and sizes for each strap setting. The sweeps cover:
- the first, last and one interior byte of every 8 KB granule;
- both strap settings;
- every combination of supply, write-protect and reset-pin level.

Together these confirm the mirrored layout and the full permission table.

// File: rtl/bootsect_pkg.sv
package bootsect_pkg;
   localparam int NUM_BLK = 5;
   localparam int IDX_W   = 3;

   typedef enum logic [1:0] {
      RP_LOW   = 2'b00,
      RP_HIGH  = 2'b01,
      RP_SUPER = 2'b10,
      RP_BAD   = 2'b11
   } rp_lvl_e;

   typedef enum logic [1:0] {
      DC_NONE   = 2'b00,
      DC_SUPPLY = 2'b01,
      DC_LOCKED = 2'b10,
      DC_RESET  = 2'b11
   } deny_e;

   typedef enum logic [IDX_W-1:0] {
      BK_BOOT    = 3'd0,
      BK_PARAM_A = 3'd1,
      BK_PARAM_B = 3'd2,
      BK_MAIN_S  = 3'd3,
      BK_MAIN_L  = 3'd4
   } blk_e;
endpackage

// File: rtl/bootsect_layout.sv
module bootsect_layout
   import bootsect_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int GRAN_LOG = 13,
   parameter int BOOT_G   = 2,
   parameter int PARAM_G  = 1,
   parameter int MAIN_S_G = 12,
   parameter int MAIN_L_G = 16,
   parameter int BOOT_SEL = 0   // 0: strap pin, 1: fixed top, 2: fixed bottom
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              boot_top_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] size_o
);
   localparam int G_W     = ADDR_W - GRAN_LOG;
   localparam int TOTAL_G = 1 << G_W;
   localparam int SUM_G   = BOOT_G + 2*PARAM_G + MAIN_S_G + MAIN_L_G;

   if (SUM_G != TOTAL_G) begin : g_bad_sum
      $error("bootsect_layout: block sizes do not fill the array");
   end
   if (BOOT_SEL < 0 || BOOT_SEL > 2) begin : g_bad_sel
      $error("bootsect_layout: BOOT_SEL out of range");
   end
   if (GRAN_LOG < 1 || GRAN_LOG >= ADDR_W) begin : g_bad_gran
      $error("bootsect_layout: GRAN_LOG out of range");
   end

   // Block sizes in granules, ordered outward from the boot end.
   function automatic int size_of(input int k);
      case (k)
         0:       size_of = BOOT_G;
         1, 2:    size_of = PARAM_G;
         3:       size_of = MAIN_S_G;
         default: size_of = MAIN_L_G;
      endcase
   endfunction

   // Granule just past block k, counted from the boot end.
   function automatic int edge_of(input int k);
      int acc;
      acc = 0;
      for (int j = 0; j < NUM_BLK; j++) begin
         if (j <= k) acc = acc + size_of(j);
      end
      edge_of = acc;
   endfunction

   logic top_sel;
   if (BOOT_SEL == 1) begin : g_fixed_top
      assign top_sel = 1'b1;
   end else if (BOOT_SEL == 2) begin : g_fixed_bot
      assign top_sel = 1'b0;
   end else begin : g_strap
      assign top_sel = boot_top_i;
   end

   logic [G_W-1:0] gran;
   logic [G_W-1:0] pos;
   assign gran = addr_i[ADDR_W-1:GRAN_LOG];
   assign pos  = top_sel ? ~gran : gran;   // distance from the boot end

   int pos_i;
   int idx_n;
   int base_g;
   int size_g;

   always_comb begin
      pos_i = int'(pos);
      idx_n = NUM_BLK - 1;
      for (int k = NUM_BLK - 2; k >= 0; k--) begin
         if (pos_i < edge_of(k)) idx_n = k;
      end
      size_g = size_of(idx_n);
      if (top_sel) base_g = TOTAL_G - edge_of(idx_n);
      else         base_g = edge_of(idx_n) - size_g;
   end

   assign idx_o  = IDX_W'(idx_n);
   assign base_o = ADDR_W'(base_g << GRAN_LOG);
   assign size_o = ADDR_W'(size_g << GRAN_LOG);
endmodule

// File: rtl/bootsect_guard.sv
module bootsect_guard
   import bootsect_pkg::*;
#(
   parameter int IDX_BOOT = 0
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic             wp_hi_i,
   input  logic [1:0]       rp_lvl_i,
   input  logic             vpp_ok_i,
   output logic             grant_o,
   output logic [1:0]       cause_o
);
   rp_lvl_e lvl;
   logic    is_boot;
   logic    unlocked;
   deny_e   cause;

   assign lvl      = rp_lvl_e'(rp_lvl_i);
   assign is_boot  = (idx_i == IDX_W'(IDX_BOOT));
   assign unlocked = (lvl == RP_SUPER) || wp_hi_i;

   always_comb begin
      if (lvl == RP_LOW || lvl == RP_BAD) cause = DC_RESET;
      else if (!vpp_ok_i)                 cause = DC_SUPPLY;
      else if (is_boot && !unlocked)      cause = DC_LOCKED;
      else                                cause = DC_NONE;
   end

   assign grant_o = (cause == DC_NONE);
   assign cause_o = cause;
endmodule

// File: rtl/bootsect_map.sv
module bootsect_map
   import bootsect_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int GRAN_LOG = 13,
   parameter int BOOT_G   = 2,
   parameter int PARAM_G  = 1,
   parameter int MAIN_S_G = 12,
   parameter int MAIN_L_G = 16,
   parameter int BOOT_SEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              boot_top_i,
   input  logic              wp_hi_i,
   input  logic [1:0]        rp_lvl_i,
   input  logic              vpp_ok_i,
   output logic              resp_vld_o,
   output logic [2:0]        blk_idx_o,
   output logic [ADDR_W-1:0] blk_base_o,
   output logic [ADDR_W-1:0] blk_size_o,
   output logic              grant_o,
   output logic              deny_o,
   output logic [1:0]        deny_cause_o
);
   logic [IDX_W-1:0]  idx_n;
   logic [ADDR_W-1:0] base_n;
   logic [ADDR_W-1:0] size_n;
   logic              grant_n;
   logic [1:0]        cause_n;

   bootsect_layout #(
      .ADDR_W(ADDR_W), .GRAN_LOG(GRAN_LOG), .BOOT_G(BOOT_G),
      .PARAM_G(PARAM_G), .MAIN_S_G(MAIN_S_G), .MAIN_L_G(MAIN_L_G),
      .BOOT_SEL(BOOT_SEL)
   ) u_layout (
      .addr_i(addr_i), .boot_top_i(boot_top_i),
      .idx_o(idx_n), .base_o(base_n), .size_o(size_n)
   );

   bootsect_guard #(.IDX_BOOT(0)) u_guard (
      .idx_i(idx_n), .wp_hi_i(wp_hi_i), .rp_lvl_i(rp_lvl_i),
      .vpp_ok_i(vpp_ok_i), .grant_o(grant_n), .cause_o(cause_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_vld_o   <= 1'b0;
         blk_idx_o    <= '0;
         blk_base_o   <= '0;
         blk_size_o   <= '0;
         grant_o      <= 1'b0;
         deny_o       <= 1'b0;
         deny_cause_o <= '0;
      end else begin
         resp_vld_o <= req_i;
         if (req_i) begin
            blk_idx_o    <= idx_n;
            blk_base_o   <= base_n;
            blk_size_o   <= size_n;
            grant_o      <= grant_n;
            deny_o       <= !grant_n;
            deny_cause_o <= cause_n;
         end
      end
   end
endmodule

// File: rtl/bootsect_map_chk.sv
module bootsect_map_chk #(
   parameter int ADDR_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              wp_hi_i,
   input logic [1:0]        rp_lvl_i,
   input logic              vpp_ok_i,
   input logic              resp_vld_o,
   input logic [2:0]        blk_idx_o,
   input logic [ADDR_W-1:0] blk_base_o,
   input logic [ADDR_W-1:0] blk_size_o,
   input logic              grant_o,
   input logic              deny_o,
   input logic [1:0]        deny_cause_o
);
   p_vld_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_vld_o |-> $past(req_i));

   p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !resp_vld_o && $stable(blk_idx_o) && $stable(blk_base_o)
                 && $stable(grant_o) && $stable(deny_o) && $stable(deny_cause_o));

   p_addr_in_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_vld_o |-> ({1'b0, $past(addr_i)} >= {1'b0, blk_base_o}) &&
                     ({1'b0, $past(addr_i)} < ({1'b0, blk_base_o} + {1'b0, blk_size_o})));

   p_one_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_o && deny_o));

   p_supply_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && (rp_lvl_i == 2'b01 || rp_lvl_i == 2'b10) && !vpp_ok_i
      |=> deny_o && deny_cause_o == 2'b01);

   p_boot_only_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && rp_lvl_i == 2'b01 && vpp_ok_i && !wp_hi_i
      |=> grant_o == (blk_idx_o != 3'd0));

   p_super_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && rp_lvl_i == 2'b10 && vpp_ok_i |=> grant_o);

   p_reset_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && (rp_lvl_i == 2'b00 || rp_lvl_i == 2'b11)
      |=> deny_o && deny_cause_o == 2'b11);

   p_grant_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> deny_cause_o == 2'b00);
endmodule

bind bootsect_map bootsect_map_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
   .wp_hi_i(wp_hi_i), .rp_lvl_i(rp_lvl_i), .vpp_ok_i(vpp_ok_i),
   .resp_vld_o(resp_vld_o), .blk_idx_o(blk_idx_o), .blk_base_o(blk_base_o),
   .blk_size_o(blk_size_o), .grant_o(grant_o), .deny_o(deny_o),
   .deny_cause_o(deny_cause_o)
);

// File: tb/bootsect_map_test.sv
module bootsect_map_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [17:0] addr_i = '0;
   logic        boot_top_i = 1'b0;
   logic        wp_hi_i = 1'b0;
   logic [1:0]  rp_lvl_i = 2'b01;
   logic        vpp_ok_i = 1'b0;
   logic        resp_vld_o;
   logic [2:0]  blk_idx_o;
   logic [17:0] blk_base_o;
   logic [17:0] blk_size_o;
   logic        grant_o;
   logic        deny_o;
   logic [1:0]  deny_cause_o;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   bootsect_map uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
      .boot_top_i(boot_top_i), .wp_hi_i(wp_hi_i), .rp_lvl_i(rp_lvl_i),
      .vpp_ok_i(vpp_ok_i), .resp_vld_o(resp_vld_o), .blk_idx_o(blk_idx_o),
      .blk_base_o(blk_base_o), .blk_size_o(blk_size_o), .grant_o(grant_o),
      .deny_o(deny_o), .deny_cause_o(deny_cause_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<100000", cycles);
         finish_run();
      end
   end

   // Expected layout measured outward from the boot end.
   function automatic int e_start(input int i);
      case (i)
         0: e_start = 'h00000;
         1: e_start = 'h04000;
         2: e_start = 'h06000;
         3: e_start = 'h08000;
         default: e_start = 'h20000;
      endcase
   endfunction

   function automatic int e_size(input int i);
      case (i)
         0: e_size = 'h4000;
         1, 2: e_size = 'h2000;
         3: e_size = 'h18000;
         default: e_size = 'h20000;
      endcase
   endfunction

   function automatic int e_idx(input int a, input bit top);
      int p;
      p = top ? ('h3FFFF - a) : a;
      if (p < 'h4000) e_idx = 0;
      else if (p < 'h6000) e_idx = 1;
      else if (p < 'h8000) e_idx = 2;
      else if (p < 'h20000) e_idx = 3;
      else e_idx = 4;
   endfunction

   function automatic int e_base(input int i, input bit top);
      e_base = top ? ('h40000 - e_start(i) - e_size(i)) : e_start(i);
   endfunction

   task automatic one_req(input int a, input bit top, input bit wp, input int lvl, input bit vpp);
      int ei, eb, ecause;
      bit egrant;
      string tag, ptag;
      int old_idx, old_cause;
      bit old_grant;
      // caller is at a falling edge
      addr_i = 18'(a); boot_top_i = top; wp_hi_i = wp;
      rp_lvl_i = 2'(lvl); vpp_ok_i = vpp; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      ei = e_idx(a, top);
      eb = e_base(ei, top);
      tag = (ei == 0) ? "R1" : (ei < 3) ? "R2" : "R3";
      if (lvl == 0 || lvl == 3) begin ecause = 3; ptag = "R11"; end
      else if (!vpp) begin ecause = 1; ptag = "R6"; end
      else if (ei == 0 && lvl != 2 && !wp) begin ecause = 2; ptag = "R7"; end
      else begin
         ecause = 0;
         ptag = (lvl == 2) ? "R9" : (ei == 0) ? "R8" : "R10";
      end
      egrant = (ecause == 0);
      check(resp_vld_o == 1'b1, "R5 valid", int'(resp_vld_o), 1);
      check(int'(blk_idx_o) == ei, tag, int'(blk_idx_o), ei);
      check(int'(blk_base_o) == eb, "R4 base", int'(blk_base_o), eb);
      check(int'(blk_size_o) == e_size(ei), "R4 size", int'(blk_size_o), e_size(ei));
      check(grant_o == egrant && deny_o == !egrant, ptag, {grant_o, deny_o}, {egrant, !egrant});
      check(int'(deny_cause_o) == ecause, ptag, int'(deny_cause_o), ecause);
      // idle cycle with disturbed inputs: nothing may move (R5)
      old_idx = int'(blk_idx_o); old_cause = int'(deny_cause_o); old_grant = grant_o;
      addr_i = ~addr_i; wp_hi_i = ~wp_hi_i; vpp_ok_i = ~vpp_ok_i; boot_top_i = ~boot_top_i;
      @(negedge clk);
      check(resp_vld_o == 1'b0 && int'(blk_idx_o) == old_idx && grant_o == old_grant
            && int'(deny_cause_o) == old_cause, "R5 hold",
            {resp_vld_o, grant_o, blk_idx_o, deny_cause_o}, {1'b0, old_grant, 3'(old_idx), 2'(old_cause)});
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R12: reset holds all outputs at zero
      check(resp_vld_o == 0 && blk_idx_o == 0 && blk_base_o == 0 && blk_size_o == 0
            && grant_o == 0 && deny_o == 0 && deny_cause_o == 0, "R12 reset",
            {resp_vld_o, grant_o, deny_o, deny_cause_o, blk_idx_o}, 0);
      req_i = 1'b1;
      @(negedge clk);
      check(resp_vld_o == 0 && grant_o == 0 && deny_o == 0, "R12 reset with strobe",
            {resp_vld_o, grant_o, deny_o}, 0);
      req_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      for (int top = 0; top < 2; top++) begin
         for (int g = 0; g < 32; g++) begin
            for (int o = 0; o < 3; o++) begin
               int off;
               off = (o == 0) ? 0 : (o == 1) ? 'h1FFF : ((g * 37 + 'hA5) & 'h1FFF);
               for (int combo = 0; combo < 16; combo++) begin
                  one_req((g << 13) | off, top[0], combo[0], combo >> 2, combo[1]);
               end
            end
         end
      end
      finish_run();
   end
endmodule